// File: doc/BRIEF.md
# Out-of-Order Floating-Point Scheduling Core

This block accepts one decoded floating-point operation per cycle, in program order, and hands it to a free slot of the matching kind. There are three kinds of slot. Load slots hold loads. Add slots hold additions and subtractions. Multiply slots hold multiplications. When an operation is placed, each of its sources is either copied from the register file or renamed to the tag of the slot that will produce it. The register file entry for its destination is then marked as owned by the new slot.

Each slot counts down its own latency once all of its operands are present. A finished slot competes for a single result bus. When it wins, its value is delivered in the same cycle to every slot waiting on its tag, and to any register that still names it as owner. Execution and completion may happen out of order, while issue stays in order.

No arithmetic unit or memory is modelled. Each result comes from a simple stand-in function, and each load returns a value supplied with the operation. A read port lets the register file be observed.

Top module: `dyn_sched_core`

## Requirements
- R1: With default parameters there are 3 load slots (tags 0..2), 3 add slots (tags 3..5) and 2 multiply slots (tags 6..7). `iss_ready` is high only when a slot of the class selected by `iss_op` is free; when it is low, no operation is accepted. Opcode values are: 0 load, 1 add, 2 subtract, 3 multiply.
- R2: An accepted operation takes the lowest-numbered free slot of its class. That slot number becomes its tag.
- R3: After an operation is accepted, its destination register reads pending with that tag. A source register that is not pending is copied at issue. A pending source waits on the owner's tag.
- R4: Once all operands are present, a slot counts down its latency. Its result is broadcast exactly latency+1 cycles after the issue cycle, or after the cycle the last operand arrived, when the bus is free. Default latencies are 2 for add/subtract and 4 for multiply.
- R5: A load has latency 1 when `iss_hit` is 1 and latency 8 otherwise. Several loads can be in flight together, so a later hit can broadcast before an earlier miss.
- R6: Broadcast values are computed as follows. A load returns its `iss_imm`. Add gives a+b and subtract gives a-b, each modulo 2^DW. Multiply gives the low DW bits of a*b.
- R7: Every slot waiting on a tag captures the value in the cycle that tag is broadcast.
- R8: A broadcast writes a register, and clears its pending flag, only if that register still names the broadcasting tag. A result whose destination was renamed later leaves the register untouched.
- R9: One broadcast occurs per cycle. Among finished slots, the lowest tag wins, and the others keep their results and win in later cycles.
- R10: An operation issued in the cycle its source's tag is broadcast takes the bus value instead of waiting.
- R11: A slot frees in its broadcast cycle. It can be allocated again from the following cycle, but not in the broadcast cycle itself.
- R12: After reset all slots are free, no register is pending, and register k holds the value k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An operation is offered this cycle |
| iss_op | input | 2 | Opcode: 0 load, 1 add, 2 subtract, 3 multiply |
| iss_dst | input | $clog2(NREG) | Destination register |
| iss_src1 | input | $clog2(NREG) | First source register |
| iss_src2 | input | $clog2(NREG) | Second source register |
| iss_imm | input | DW | Value returned by a load |
| iss_hit | input | 1 | Load uses the short latency |
| iss_ready | output | 1 | A slot of the offered class is free |
| rd_addr | input | $clog2(NREG) | Register read address |
| rd_value | output | DW | Current value of that register |
| rd_pend | output | 1 | Register is waiting on a producer |
| rd_tag | output | $clog2(total slots) | Producer tag of that register |
| cdb_valid | output | 1 | A result is broadcast this cycle |
| cdb_tag | output | $clog2(total slots) | Tag of the broadcasting slot |
| cdb_value | output | DW | Broadcast result |

## Verification
The renaming and countdown logic is exercised with several patterns. Independent operations show the exact latency+1 timing. A miss load followed by a hit load shows completion out of issue order. A multiply waiting on both loads shows operand capture at two different broadcasts. Two writers to the same register show that the stale result is dropped. Further cases cover the remaining corners: an operation issued in the same cycle as its producer's broadcast, two slots finishing in the same cycle (the lower tag must go first), and a full load class that must stall until exactly the cycle after a load slot broadcasts.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [1:0] {
        OP_LD  = 2'd0,
        OP_ADD = 2'd1,
        OP_SUB = 2'd2,
        OP_MUL = 2'd3
    } dsc_op_e;

    typedef enum logic [1:0] {
        CL_LD = 2'd0,
        CL_AS = 2'd1,
        CL_MD = 2'd2
    } dsc_cls_e;

    function automatic dsc_cls_e op_class(dsc_op_e op);
        case (op)
            OP_LD:   return CL_LD;
            OP_MUL:  return CL_MD;
            default: return CL_AS;
        endcase
    endfunction

endpackage

// File: rtl/dsc_pick.sv
// Lowest-index-first one-hot picker.
module dsc_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dsc_station.sv
// One scheduling slot: holds operands or producer tags, counts down its latency.
module dsc_station
    import dsc_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 3,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  dsc_op_e       a_op,
    input  logic [DW-1:0] a_v1,
    input  logic [DW-1:0] a_v2,
    input  logic          a_w1,
    input  logic          a_w2,
    input  logic [TW-1:0] a_q1,
    input  logic [TW-1:0] a_q2,
    input  logic [CW-1:0] a_lat,
    input  logic          cdb_valid,
    input  logic [TW-1:0] cdb_tag,
    input  logic [DW-1:0] cdb_value,
    input  logic          grant,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] result
);
    typedef struct packed {
        logic          busy;
        dsc_op_e       op;
        logic [DW-1:0] v1;
        logic [DW-1:0] v2;
        logic [TW-1:0] q1;
        logic [TW-1:0] q2;
        logic          w1;
        logic          w2;
        logic [CW-1:0] cnt;
    } ent_t;

    ent_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (grant) begin
            st_d.busy = 1'b0;
        end else if (alloc) begin
            st_d.busy = 1'b1;
            st_d.op   = a_op;
            st_d.v1   = a_v1;
            st_d.v2   = a_v2;
            st_d.q1   = a_q1;
            st_d.q2   = a_q2;
            st_d.w1   = a_w1;
            st_d.w2   = a_w2;
            st_d.cnt  = a_lat;
        end else if (st_q.busy) begin
            if (st_q.w1 && cdb_valid && cdb_tag == st_q.q1) begin
                st_d.v1 = cdb_value;
                st_d.w1 = 1'b0;
            end
            if (st_q.w2 && cdb_valid && cdb_tag == st_q.q2) begin
                st_d.v2 = cdb_value;
                st_d.w2 = 1'b0;
            end
            if (!st_q.w1 && !st_q.w2 && st_q.cnt != '0)
                st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign done = st_q.busy && !st_q.w1 && !st_q.w2 && st_q.cnt == '0;

    always_comb begin
        case (st_q.op)
            OP_LD:   result = st_q.v1;
            OP_ADD:  result = st_q.v1 + st_q.v2;
            OP_SUB:  result = st_q.v1 - st_q.v2;
            default: result = st_q.v1 * st_q.v2;
        endcase
    end

    // R2: allocation only ever targets a free slot
    a_r2_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !st_q.busy);
    // R9: only a finished slot may own the bus
    a_r9_grant_done: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> done);
    // R9: a finished slot that loses keeps its result for the retry
    a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !grant) |=> (done && $stable(result)));
    // R4: countdown frozen while any operand is missing
    a_r4_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && (st_q.w1 || st_q.w2)) |=> $stable(st_q.cnt));
endmodule

// File: rtl/dyn_sched_core.sv
module dyn_sched_core
    import dsc_pkg::*;
#(
    parameter int NREG        = 8,
    parameter int DW          = 16,
    parameter int N_LD        = 3,
    parameter int N_AS        = 3,
    parameter int N_MD        = 2,
    parameter int LAT_LD_MISS = 8,
    parameter int LAT_LD_HIT  = 1,
    parameter int LAT_AS      = 2,
    parameter int LAT_MD      = 4,
    localparam int NST  = N_LD + N_AS + N_MD,
    localparam int TW   = $clog2(NST),
    localparam int RW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic [1:0]    iss_op,
    input  logic [RW-1:0] iss_dst,
    input  logic [RW-1:0] iss_src1,
    input  logic [RW-1:0] iss_src2,
    input  logic [DW-1:0] iss_imm,
    input  logic          iss_hit,
    output logic          iss_ready,
    input  logic [RW-1:0] rd_addr,
    output logic [DW-1:0] rd_value,
    output logic          rd_pend,
    output logic [TW-1:0] rd_tag,
    output logic          cdb_valid,
    output logic [TW-1:0] cdb_tag,
    output logic [DW-1:0] cdb_value
);
    localparam int LMAX_A = (LAT_LD_MISS > LAT_LD_HIT) ? LAT_LD_MISS : LAT_LD_HIT;
    localparam int LMAX_B = (LAT_AS > LAT_MD) ? LAT_AS : LAT_MD;
    localparam int LMAX   = (LMAX_A > LMAX_B) ? LMAX_A : LMAX_B;
    localparam int CW     = $clog2(LMAX + 1);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] val;
        logic [NREG-1:0]         pend;
        logic [NREG-1:0][TW-1:0] tag;
    } rf_t;

    function automatic dsc_cls_e slot_class(int s);
        if (s < N_LD)        return CL_LD;
        if (s < N_LD + N_AS) return CL_AS;
        return CL_MD;
    endfunction

    function automatic rf_t rf_reset();
        rf_t r;
        r = '0;
        for (int k = 0; k < NREG; k++) r.val[k] = DW'(k);
        return r;
    endfunction

    rf_t rf_d, rf_q;

    dsc_op_e               op_e;
    logic [NST-1:0]        st_busy, st_done, st_free;
    logic [NST-1:0][DW-1:0] st_res;
    logic [NST-1:0]        cdb_gnt, alloc_gnt, alloc_vec;
    logic [TW-1:0]         alloc_tag;
    logic                  do_iss;
    logic [DW-1:0]         a_v1, a_v2;
    logic                  a_w1, a_w2;
    logic [TW-1:0]         a_q1, a_q2;
    logic [CW-1:0]         a_lat;

    assign op_e = dsc_op_e'(iss_op);

    // ---- result bus arbitration ----
    dsc_pick #(.N(NST)) u_cdb_pick (.req(st_done), .gnt(cdb_gnt));

    always_comb begin
        cdb_tag = '0;
        for (int s = 0; s < NST; s++)
            if (cdb_gnt[s]) cdb_tag = cdb_tag | TW'(s);
    end
    assign cdb_valid = |cdb_gnt;
    assign cdb_value = st_res[cdb_tag];

    // ---- free slot selection ----
    always_comb begin
        for (int s = 0; s < NST; s++)
            st_free[s] = !st_busy[s] && (slot_class(s) == op_class(op_e));
    end

    dsc_pick #(.N(NST)) u_alloc_pick (.req(st_free), .gnt(alloc_gnt));

    always_comb begin
        alloc_tag = '0;
        for (int s = 0; s < NST; s++)
            if (alloc_gnt[s]) alloc_tag = alloc_tag | TW'(s);
    end
    assign iss_ready = |alloc_gnt;
    assign do_iss    = iss_valid && iss_ready;
    assign alloc_vec = alloc_gnt & {NST{iss_valid}};

    // ---- operand renaming with same-cycle bus bypass ----
    always_comb begin
        a_v1 = rf_q.val[iss_src1];
        a_q1 = rf_q.tag[iss_src1];
        a_w1 = 1'b0;
        if (rf_q.pend[iss_src1]) begin
            if (cdb_valid && cdb_tag == rf_q.tag[iss_src1]) a_v1 = cdb_value;
            else                                            a_w1 = 1'b1;
        end
        a_v2 = rf_q.val[iss_src2];
        a_q2 = rf_q.tag[iss_src2];
        a_w2 = 1'b0;
        if (rf_q.pend[iss_src2]) begin
            if (cdb_valid && cdb_tag == rf_q.tag[iss_src2]) a_v2 = cdb_value;
            else                                            a_w2 = 1'b1;
        end
        a_lat = CW'(LAT_AS);
        case (op_e)
            OP_LD: begin
                a_v1  = iss_imm;
                a_w1  = 1'b0;
                a_w2  = 1'b0;
                a_lat = iss_hit ? CW'(LAT_LD_HIT) : CW'(LAT_LD_MISS);
            end
            OP_MUL:  a_lat = CW'(LAT_MD);
            default: ;
        endcase
    end

    // ---- slots ----
    for (genvar s = 0; s < NST; s++) begin : g_st
        dsc_station #(.DW(DW), .TW(TW), .CW(CW)) u_st (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc     (alloc_vec[s]),
            .a_op      (op_e),
            .a_v1      (a_v1),
            .a_v2      (a_v2),
            .a_w1      (a_w1),
            .a_w2      (a_w2),
            .a_q1      (a_q1),
            .a_q2      (a_q2),
            .a_lat     (a_lat),
            .cdb_valid (cdb_valid),
            .cdb_tag   (cdb_tag),
            .cdb_value (cdb_value),
            .grant     (cdb_gnt[s]),
            .busy      (st_busy[s]),
            .done      (st_done[s]),
            .result    (st_res[s])
        );
    end

    // ---- register status and values ----
    always_comb begin
        rf_d = rf_q;
        for (int r = 0; r < NREG; r++) begin
            if (cdb_valid && rf_q.pend[r] && rf_q.tag[r] == cdb_tag) begin
                rf_d.val[r]  = cdb_value;
                rf_d.pend[r] = 1'b0;
            end
        end
        if (do_iss) begin
            rf_d.pend[iss_dst] = 1'b1;
            rf_d.tag[iss_dst]  = alloc_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rf_q <= rf_reset();
        else        rf_q <= rf_d;
    end

    assign rd_value = rf_q.val[rd_addr];
    assign rd_pend  = rf_q.pend[rd_addr];
    assign rd_tag   = rf_q.tag[rd_addr];

    // R11: the broadcasting slot is free in the next cycle
    a_r11_free_after_bcast: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |=> !st_busy[$past(cdb_tag)]);
    // R9: no lower-numbered slot is finished while another broadcasts
    a_r9_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |-> ((st_done & ((NST'(1) << cdb_tag) - NST'(1))) == '0));
    // R3: accepted destination is marked pending with the new tag
    a_r3_dst_marked: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=>
            (rf_q.pend[$past(iss_dst)] && rf_q.tag[$past(iss_dst)] == $past(alloc_tag)));
    // R1: a stalled offer allocates no slot
    a_r1_stall_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> ((st_busy & ~$past(st_busy)) == '0));
endmodule

// File: tb/test_dyn_sched_core.sv
module test_dyn_sched_core;
    localparam int RW = 3;
    localparam int TW = 3;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [1:0]    iss_op = 2'd0;
    logic [RW-1:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic [DW-1:0] iss_imm = '0;
    logic          iss_hit = 1'b0;
    logic          iss_ready;
    logic [RW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_value;
    logic          rd_pend;
    logic [TW-1:0] rd_tag;
    logic          cdb_valid;
    logic [TW-1:0] cdb_tag;
    logic [DW-1:0] cdb_value;

    always #4 clk = ~clk;

    dyn_sched_core i_dyn_sched_core (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_imm(iss_imm), .iss_hit(iss_hit), .iss_ready(iss_ready),
        .rd_addr(rd_addr), .rd_value(rd_value), .rd_pend(rd_pend), .rd_tag(rd_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int lc[512];
    int lt[512];
    int lv[512];
    int nlog = 0;
    always @(negedge clk) begin
        if (rst_n && cdb_valid && nlog < 512) begin
            lc[nlog] = cyc;
            lt[nlog] = int'(cdb_tag);
            lv[nlog] = int'(cdb_value);
            nlog = nlog + 1;
        end
    end

    int nchk = 0;
    int nfail = 0;
    bit wd = 1'b0;

    task automatic tick(int k = 1);
        repeat (k) @(posedge clk);
        #1;
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int find_bc(int tag, int from);
        for (int i = 0; i < nlog; i++)
            if (lt[i] == tag && lc[i] >= from) return i;
        return -1;
    endfunction

    task automatic chk_bc(int tag, int from, int ecyc, int eval, string req);
        int i;
        i = find_bc(tag, from);
        if (i < 0) begin
            chk(1'b0, {req, " broadcast missing"}, -1, ecyc);
        end else begin
            chk(lc[i] == ecyc, {req, " broadcast cycle"}, lc[i], ecyc);
            chk(lv[i] == eval, {req, " broadcast value"}, lv[i], eval);
        end
    endtask

    task automatic issue(int op, int dst, int s1, int s2, int imm, bit hit, output int c);
        iss_valid = 1'b1;
        iss_op    = 2'(op);
        iss_dst   = RW'(dst);
        iss_src1  = RW'(s1);
        iss_src2  = RW'(s2);
        iss_imm   = DW'(imm);
        iss_hit   = hit;
        c = cyc;
        tick();
        iss_valid = 1'b0;
    endtask

    task automatic rd(int r, output int v, output int p, output int t);
        rd_addr = RW'(r);
        #1;
        v = int'(rd_value);
        p = int'(rd_pend);
        t = int'(rd_tag);
    endtask

    task automatic t_reset();
        int v, p, t;
        iss_valid = 1'b0;
        iss_op = 2'd0; #1;
        chk(iss_ready == 1'b1, "R12 load slot free", int'(iss_ready), 1);
        iss_op = 2'd1; #1;
        chk(iss_ready == 1'b1, "R12 add slot free", int'(iss_ready), 1);
        iss_op = 2'd3; #1;
        chk(iss_ready == 1'b1, "R12 mul slot free", int'(iss_ready), 1);
        rd(5, v, p, t);
        chk(v == 5, "R12 reg value", v, 5);
        chk(p == 0, "R12 reg not pending", p, 0);
        chk(cdb_valid == 1'b0, "R12 bus idle", int'(cdb_valid), 0);
    endtask

    task automatic t_indep();
        int n, c, v, p, t;
        issue(1, 1, 2, 3, 0, 0, n);   // add F1=F2+F3 -> tag3
        issue(2, 7, 3, 2, 0, 0, c);   // sub F7=F3-F2 -> tag4
        rd(1, v, p, t);
        chk(p == 1, "R3 dst pending", p, 1);
        chk(t == 3, "R2 first add slot tag", t, 3);
        rd(7, v, p, t);
        chk(t == 4, "R2 second add slot tag", t, 4);
        tick(6);
        chk_bc(3, n, n + 3, 5, "R4 R6 add");
        chk_bc(4, n, n + 4, 1, "R4 R6 sub");
        rd(1, v, p, t);
        chk(v == 5 && p == 0, "R8 add written", v, 5);
    endtask

    task automatic t_loads();
        int n, c;
        issue(0, 0, 0, 0, 100, 0, n); // miss -> tag0
        issue(0, 2, 0, 0, 7, 1, c);   // hit  -> tag1
        issue(3, 4, 0, 2, 0, 0, c);   // mul F4=F0*F2 -> tag6
        tick(14);
        chk_bc(1, n, n + 3, 7, "R5 hit load");
        chk_bc(0, n, n + 9, 100, "R5 miss load");
        chk_bc(6, n, n + 14, 700, "R7 R6 mul");
    endtask

    task automatic t_waw();
        int n, c, v, p, t;
        issue(1, 1, 2, 3, 0, 0, n);   // add F1=7+3 -> tag3
        issue(0, 1, 0, 0, 9, 0, c);   // load F1 miss -> tag0
        tick(2);
        rd(1, v, p, t);
        chk_bc(3, n, n + 3, 10, "R8 older add");
        chk(v == 5 && p == 1 && t == 0, "R8 stale result dropped", v, 5);
        tick(8);
        rd(1, v, p, t);
        chk(v == 9 && p == 0, "R8 newer load written", v, 9);
    endtask

    task automatic t_bypass();
        int n, c;
        issue(0, 5, 0, 0, 20, 1, n);  // load F5 hit -> tag0, bcast n+2
        tick();
        chk(cdb_valid && cdb_tag == 3'd0, "R10 producer on bus at issue", int'(cdb_tag), 0);
        issue(1, 6, 5, 5, 0, 0, c);   // add F6=F5+F5 in bcast cycle
        tick(8);
        chk_bc(3, n, n + 5, 40, "R10 bypass add");
    endtask

    task automatic t_arb();
        int n, c;
        issue(1, 3, 0, 2, 0, 0, n);   // add F3=100+7 -> tag3 done n+3
        issue(0, 4, 0, 0, 3, 1, c);   // load hit -> tag0 done n+3
        tick(6);
        chk_bc(0, n, n + 3, 3, "R9 lower tag first");
        chk_bc(3, n, n + 4, 107, "R9 loser retries");
    endtask

    task automatic t_stall();
        int n, c, v, p, t, a;
        issue(0, 5, 0, 0, 1, 0, n);
        issue(0, 6, 0, 0, 2, 0, c);
        issue(0, 7, 0, 0, 3, 0, c);
        iss_op = 2'd1; #1;
        chk(iss_ready == 1'b1, "R1 add class still free", int'(iss_ready), 1);
        iss_op = 2'd0; #1;
        chk(iss_ready == 1'b0, "R1 load class full", int'(iss_ready), 0);
        rd_addr = 3'd1;
        iss_dst = 3'd1; iss_imm = 16'd4; iss_hit = 1'b1;
        iss_valid = 1'b1;
        a = -1;
        while (a < 0) begin
            #1;
            if (cyc == n + 9) begin
                chk(cdb_valid && cdb_tag == 3'd0 && !iss_ready,
                    "R11 no reuse in bcast cycle", int'(iss_ready), 0);
                chk(rd_pend == 1'b0, "R1 stalled op not accepted", int'(rd_pend), 0);
            end
            if (iss_ready) a = cyc;
            tick();
        end
        iss_valid = 1'b0;
        chk(a == n + 10, "R11 reuse next cycle", a, n + 10);
        rd(1, v, p, t);
        chk(p == 1 && t == 0, "R2 lowest free load slot", t, 0);
        tick(12);
    endtask

    initial begin
        fork
            begin
                tick(3);
                rst_n = 1'b1;
                tick();
                t_reset();
                t_indep();
                tick(4);
                t_loads();
                tick(4);
                t_waw();
                tick(4);
                t_bypass();
                tick(4);
                t_arb();
                tick(4);
                t_stall();
            end
            begin
                repeat (200000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        if (wd) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        end
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule